// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets firmware running on the chip rewrite its own byte-wide program flash. The processor reaches it through a small write port. There are two address bytes, a data byte, a command byte and a configuration byte. Reads of the array go through a separate read port. The block can program a byte, erase one 512-byte page, erase the whole array, or read-protect the array. While a command runs, the controller holds the processor and ignores all register writes. Each command lasts a fixed number of clock cycles, set by a parameter.

The array holds `2**DEPTH_W` bytes. A boot region of n×512 bytes sits at the top of the array, where n comes from the `boot_pages` input. Two things guard the array. A three-write key must be written to the data byte before a start is accepted. Commands aimed at the boot region, or at addresses past the array, leave the array unchanged. The array contents and the protection flag keep their values through a reset. The boot address is chosen while reset is held low.

Top module: `flash_selfprog`

## Requirements
- R1: After reset, `cpu_hold` is 0, the enable bit is 0 and the key is disarmed. The array bytes and the protection flag keep their values across the reset.
- R2: The key is armed by three data-byte writes in a row: 55h, then AAh, then 55h. A wrong value sends the key back to the start, except that a wrong 55h counts as the first key value. Writes to other registers do not disturb the key progress.
- R3: An armed key allows exactly one start, and that start disarms it. A start refused because the enable bit is 0 leaves the key armed.
- R4: Configuration bit 0 is the enable bit. A start written while the enable bit is 0 is ignored.
- R5: The register select values are 0 for the address high byte, 1 for the address low byte, 2 for data, 3 for command and 4 for configuration. In the command byte, bit 7 is start and bits 1:0 select the function: 00 program, 01 protect, 10 page erase, 11 chip erase. After an accepted start, `cpu_hold` is high for exactly T_PROG, T_PROT, T_PAGE or T_CHIP cycles, depending on the function. All register writes while `cpu_hold` is high are ignored.
- R6: Erased bytes read FFh. Byte program stores the old byte AND the data byte.
- R7: Page erase sets to FFh the whole 512-byte aligned page that holds the address, whether that page number is even or odd. Every other page is left untouched.
- R8: With n = min(`boot_pages`, 8), the top n×512 bytes form the boot region. A program or page erase aimed at that region, or at an address at or above the array size, leaves the array unchanged. The command still runs for its full duration.
- R9: Chip erase sets every byte below the boot region to FFh, leaves the boot region as it was, and clears read protection.
- R10: After protect, `rd_data` is 00h for every address until a chip erase.
- R11: While `rst_n` is low, `boot_addr` is loaded with the start of the boot region if byte 0 reads FFh and n > 0. Otherwise it is loaded with 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_pages | input | 4 | Boot region size in 512-byte pages (clamped to MAX_RESV) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| rd_addr | input | DEPTH_W | Array read address |
| cpu_hold | output | 1 | High while a command runs; the processor is held |
| rd_data | output | 8 | Array read data (00h when protected) |
| boot_addr | output | 16 | Boot address chosen during reset |

## Verification
Byte program is run with random 16-bit addresses. About a quarter of them fall past the array, so the out-of-range guard is told apart from an address that is simply cut short. Random data bytes, often written over bytes already programmed, show AND-merging apart from plain overwriting. Directed key sequences cover a broken key, the repeated-55h restart and key writes mixed with other register writes, so the restart rule can be seen at the ports. Page erases on an odd page and on an even page, with probes on the neighbouring page edges, catch alignment faults. The boot region is first filled with the region size set to zero. The bench then resets with a nonzero size, which makes the region's immunity to program, page erase and chip erase visible at the read port.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'b00,
      OP_PROT = 2'b01,
      OP_PGER = 2'b10,
      OP_CHER = 2'b11
   } fsp_op_e;

   typedef enum logic [2:0] {
      SEL_AHI  = 3'd0,
      SEL_ALO  = 3'd1,
      SEL_DATA = 3'd2,
      SEL_CTRL = 3'd3,
      SEL_CFG  = 3'd4
   } fsp_sel_e;

   localparam logic [7:0] KEY_OUTER   = 8'h55;
   localparam logic [7:0] KEY_INNER   = 8'hAA;
   localparam int         CTRL_GO_BIT = 7;

   typedef struct packed {
      fsp_op_e     op;
      logic [15:0] addr;
      logic [7:0]  data;
   } fsp_cmd_t;

endpackage

// File: rtl/fsp_keylock.sv
module fsp_keylock
   import fsp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_wr,
   input  logic [7:0] data_val,
   input  logic       consume,
   output logic       armed
);

   typedef enum logic [1:0] {K_IDLE, K_ONE, K_TWO} kst_e;

   kst_e st_q;
   logic is_outer;
   logic is_inner;

   assign is_outer = (data_val == KEY_OUTER);
   assign is_inner = (data_val == KEY_INNER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= K_IDLE;
         armed <= 1'b0;
      end else begin
         if (consume) armed <= 1'b0;
         if (data_wr) begin
            case (st_q)
               K_IDLE:  st_q <= is_outer ? K_ONE : K_IDLE;
               K_ONE:   st_q <= is_inner ? K_TWO : (is_outer ? K_ONE : K_IDLE);
               K_TWO: begin
                  if (is_outer) armed <= 1'b1;
                  st_q <= K_IDLE;
               end
               default: st_q <= K_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/fsp_sequencer.sv
module fsp_sequencer
   import fsp_pkg::*;
#(
   parameter int DEPTH_W = 12,
   parameter int PAGE_W  = 9,
   parameter int T_PROG  = 4,
   parameter int T_PROT  = 8,
   parameter int T_PAGE  = 600,
   parameter int T_CHIP  = 4200
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  fsp_cmd_t           cmd,
   input  logic [DEPTH_W:0]   resv_base,
   output logic               busy,
   output logic               pgm_stb,
   output logic [DEPTH_W-1:0] pgm_addr,
   output logic [7:0]         pgm_data,
   output logic               ers_stb,
   output logic [DEPTH_W-1:0] ers_addr,
   output logic               prot_set,
   output logic               prot_clr,
   output fsp_op_e            cur_op
);

   localparam int DEPTH      = 1 << DEPTH_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int T_AB       = (T_PROG > T_PROT) ? T_PROG : T_PROT;
   localparam int T_CD       = (T_PAGE > T_CHIP) ? T_PAGE : T_CHIP;
   localparam int T_MAX      = (T_AB > T_CD) ? T_AB : T_CD;
   localparam int TMR_W      = $clog2(T_MAX + 1);

   if (T_PROG < 1 || T_PROT < 1) begin : g_bad_short
      $error("fsp_sequencer: program and protect durations must be at least one cycle");
   end
   if (T_PAGE < PAGE_BYTES) begin : g_bad_page
      $error("fsp_sequencer: T_PAGE must cover one cycle per byte of a page");
   end
   if (T_CHIP < DEPTH) begin : g_bad_chip
      $error("fsp_sequencer: T_CHIP must cover one cycle per byte of the array");
   end

   logic               busy_q;
   logic [TMR_W-1:0]   tmr_q;
   fsp_cmd_t           cmd_q;
   logic               ok_q;
   logic               first_q;
   logic [DEPTH_W-1:0] ptr_q;
   logic [DEPTH_W:0]   left_q;
   logic [TMR_W-1:0]   dur_last;
   logic               last_cyc;
   logic               launch_ok;
   logic [DEPTH_W-1:0] page_base;

   assign launch_ok = (32'(cmd.addr) < 32'(resv_base));
   assign page_base = {cmd.addr[DEPTH_W-1:PAGE_W], {PAGE_W{1'b0}}};

   always_comb begin
      case (cmd_q.op)
         OP_PROG: dur_last = TMR_W'(T_PROG - 1);
         OP_PROT: dur_last = TMR_W'(T_PROT - 1);
         OP_PGER: dur_last = TMR_W'(T_PAGE - 1);
         default: dur_last = TMR_W'(T_CHIP - 1);
      endcase
   end

   assign last_cyc = busy_q && (tmr_q == dur_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         tmr_q   <= '0;
         cmd_q   <= '0;
         ok_q    <= 1'b0;
         first_q <= 1'b0;
         ptr_q   <= '0;
         left_q  <= '0;
      end else if (!busy_q) begin
         if (launch) begin
            busy_q  <= 1'b1;
            tmr_q   <= '0;
            cmd_q   <= cmd;
            ok_q    <= launch_ok;
            first_q <= 1'b1;
            case (cmd.op)
               OP_PGER: begin
                  ptr_q  <= page_base;
                  left_q <= launch_ok ? (DEPTH_W+1)'(PAGE_BYTES) : '0;
               end
               OP_CHER: begin
                  ptr_q  <= '0;
                  left_q <= resv_base;
               end
               default: begin
                  ptr_q  <= '0;
                  left_q <= '0;
               end
            endcase
         end
      end else begin
         first_q <= 1'b0;
         if (left_q != '0) begin
            ptr_q  <= ptr_q + 1'b1;
            left_q <= left_q - 1'b1;
         end
         if (last_cyc) busy_q <= 1'b0;
         else          tmr_q  <= tmr_q + 1'b1;
      end
   end

   assign busy     = busy_q;
   assign pgm_stb  = busy_q && first_q && ok_q && (cmd_q.op == OP_PROG);
   assign pgm_addr = cmd_q.addr[DEPTH_W-1:0];
   assign pgm_data = cmd_q.data;
   assign ers_stb  = busy_q && (left_q != '0);
   assign ers_addr = ptr_q;
   assign prot_set = last_cyc && (cmd_q.op == OP_PROT);
   assign prot_clr = last_cyc && (cmd_q.op == OP_CHER);
   assign cur_op   = cmd_q.op;

endmodule

// File: rtl/fsp_array.sv
module fsp_array #(
   parameter int DEPTH_W  = 12,
   parameter int READ_REG = 0
)(
   input  logic               clk,
   input  logic               pgm_stb,
   input  logic [DEPTH_W-1:0] pgm_addr,
   input  logic [7:0]         pgm_data,
   input  logic               ers_stb,
   input  logic [DEPTH_W-1:0] ers_addr,
   input  logic               prot_set,
   input  logic               prot_clr,
   input  logic [DEPTH_W-1:0] rd_addr,
   output logic [7:0]         rd_data,
   output logic               blank0
);

   localparam int DEPTH = 1 << DEPTH_W;

   logic [7:0] cells [DEPTH];
   logic       locked;
   logic [7:0] raw;

   initial begin
      for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
      locked = 1'b0;
   end

   always @(posedge clk) begin
      if (pgm_stb) cells[pgm_addr] <= cells[pgm_addr] & pgm_data;
      if (ers_stb) cells[ers_addr] <= 8'hFF;
      if (prot_set)      locked <= 1'b1;
      else if (prot_clr) locked <= 1'b0;
   end

   assign raw    = locked ? 8'h00 : cells[rd_addr];
   assign blank0 = (cells[0] == 8'hFF);

   if (READ_REG != 0) begin : g_rd_flop
      always_ff @(posedge clk) rd_data <= raw;
   end else begin : g_rd_comb
      assign rd_data = raw;
   end

endmodule

// File: rtl/flash_selfprog.sv
module flash_selfprog
   import fsp_pkg::*;
#(
   parameter int DEPTH_W  = 12,
   parameter int PAGE_W   = 9,
   parameter int MAX_RESV = 8,
   parameter int READ_REG = 0,
   parameter int T_PROG   = 4,
   parameter int T_PROT   = 8,
   parameter int T_PAGE   = 600,
   parameter int T_CHIP   = 4200
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         boot_pages,
   input  logic               reg_wr,
   input  logic [2:0]         reg_sel,
   input  logic [7:0]         reg_wdata,
   input  logic [DEPTH_W-1:0] rd_addr,
   output logic               cpu_hold,
   output logic [7:0]         rd_data,
   output logic [15:0]        boot_addr
);

   localparam int DEPTH      = 1 << DEPTH_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;

   if (DEPTH_W > 16 || DEPTH_W <= PAGE_W) begin : g_bad_depth
      $error("flash_selfprog: DEPTH_W must exceed PAGE_W and be at most 16");
   end
   if (MAX_RESV < 0 || MAX_RESV > 15 || MAX_RESV * PAGE_BYTES > DEPTH) begin : g_bad_resv
      $error("flash_selfprog: boot region limit does not fit the array");
   end

   logic [15:0]        addr_q;
   logic [7:0]         data_q;
   logic               en_q;
   logic               wr_ok;
   logic               launch;
   logic               armed;
   logic [3:0]         n_eff;
   logic [DEPTH_W:0]   resv_base;
   fsp_cmd_t           cmd;
   fsp_op_e            cur_op;
   logic               pgm_stb;
   logic [DEPTH_W-1:0] pgm_addr;
   logic [7:0]         pgm_data;
   logic               ers_stb;
   logic [DEPTH_W-1:0] ers_addr;
   logic               prot_set;
   logic               prot_clr;
   logic               blank0;
   logic [15:0]        boot_q;

   assign n_eff     = (boot_pages > 4'(MAX_RESV)) ? 4'(MAX_RESV) : boot_pages;
   assign resv_base = (DEPTH_W+1)'(DEPTH - int'(n_eff) * PAGE_BYTES);

   assign wr_ok  = reg_wr && !cpu_hold;
   assign launch = wr_ok && (reg_sel == SEL_CTRL) && reg_wdata[CTRL_GO_BIT]
                   && armed && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         en_q   <= 1'b0;
      end else if (wr_ok) begin
         case (reg_sel)
            SEL_AHI:  addr_q[15:8] <= reg_wdata;
            SEL_ALO:  addr_q[7:0]  <= reg_wdata;
            SEL_DATA: data_q       <= reg_wdata;
            SEL_CFG:  en_q         <= reg_wdata[0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      cmd      = '0;
      cmd.op   = fsp_op_e'(reg_wdata[1:0]);
      cmd.addr = addr_q;
      cmd.data = data_q;
   end

   fsp_keylock u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (wr_ok && (reg_sel == SEL_DATA)),
      .data_val (reg_wdata),
      .consume  (launch),
      .armed    (armed)
   );

   fsp_sequencer #(
      .DEPTH_W (DEPTH_W),
      .PAGE_W  (PAGE_W),
      .T_PROG  (T_PROG),
      .T_PROT  (T_PROT),
      .T_PAGE  (T_PAGE),
      .T_CHIP  (T_CHIP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .cmd       (cmd),
      .resv_base (resv_base),
      .busy      (cpu_hold),
      .pgm_stb   (pgm_stb),
      .pgm_addr  (pgm_addr),
      .pgm_data  (pgm_data),
      .ers_stb   (ers_stb),
      .ers_addr  (ers_addr),
      .prot_set  (prot_set),
      .prot_clr  (prot_clr),
      .cur_op    (cur_op)
   );

   fsp_array #(
      .DEPTH_W  (DEPTH_W),
      .READ_REG (READ_REG)
   ) u_arr (
      .clk      (clk),
      .pgm_stb  (pgm_stb),
      .pgm_addr (pgm_addr),
      .pgm_data (pgm_data),
      .ers_stb  (ers_stb),
      .ers_addr (ers_addr),
      .prot_set (prot_set),
      .prot_clr (prot_clr),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .blank0   (blank0)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= (blank0 && n_eff != 4'd0) ? 16'(resv_base) : 16'h0000;
   end

   assign boot_addr = boot_q;

endmodule

// File: rtl/flash_selfprog_chk.sv
module flash_selfprog_chk
   import fsp_pkg::*;
#(
   parameter int T_PROG = 4,
   parameter int T_PROT = 8,
   parameter int T_PAGE = 600,
   parameter int T_CHIP = 4200
)(
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [2:0]  reg_sel,
   input logic [7:0]  reg_wdata,
   input logic        cpu_hold,
   input logic        armed,
   input logic        en_q,
   input logic [15:0] addr_q,
   input fsp_op_e     cur_op
);

   logic [31:0] run_cnt;
   logic [31:0] want_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (cpu_hold) run_cnt <= run_cnt + 1;
      else               run_cnt <= '0;
   end

   always_comb begin
      case (cur_op)
         OP_PROG: want_len = 32'(T_PROG);
         OP_PROT: want_len = 32'(T_PROT);
         OP_PGER: want_len = 32'(T_PAGE);
         default: want_len = 32'(T_CHIP);
      endcase
   end

   // R2
   key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> $past(armed));

   // R3
   arm_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> !armed);

   // R4
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> $past(en_q));

   // R5
   go_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> $past(reg_wr && reg_sel == SEL_CTRL && reg_wdata[CTRL_GO_BIT]));

   // R5
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_hold) |-> run_cnt == want_len);

   // R5
   held_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold && reg_wr |=> $stable(addr_q) && $stable(en_q));

endmodule

bind flash_selfprog flash_selfprog_chk #(
   .T_PROG (T_PROG),
   .T_PROT (T_PROT),
   .T_PAGE (T_PAGE),
   .T_CHIP (T_CHIP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .cpu_hold  (cpu_hold),
   .armed     (armed),
   .en_q      (en_q),
   .addr_q    (addr_q),
   .cur_op    (cur_op)
);

// File: tb/flash_selfprog_test.sv
module flash_selfprog_test;
   import fsp_pkg::*;

   localparam int DW    = 12;
   localparam int DEPTH = 1 << DW;
   localparam int TPROG = 4;
   localparam int TPROT = 8;
   localparam int TPAGE = 600;
   localparam int TCHIP = 4200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    boot_pages = 4'd0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_sel = 3'd0;
   logic [7:0]    reg_wdata = 8'd0;
   logic [DW-1:0] rd_addr = '0;
   logic          cpu_hold;
   logic [7:0]    rd_data;
   logic [15:0]   boot_addr;

   always #4 clk = ~clk;

   flash_selfprog #(
      .DEPTH_W (DW), .PAGE_W (9), .MAX_RESV (8), .READ_REG (0),
      .T_PROG (TPROG), .T_PROT (TPROT), .T_PAGE (TPAGE), .T_CHIP (TCHIP)
   ) uut (
      .clk (clk), .rst_n (rst_n), .boot_pages (boot_pages),
      .reg_wr (reg_wr), .reg_sel (reg_sel), .reg_wdata (reg_wdata),
      .rd_addr (rd_addr), .cpu_hold (cpu_hold), .rd_data (rd_data),
      .boot_addr (boot_addr)
   );

   logic [7:0] model [DEPTH];
   logic       mprot = 1'b0;
   int         npages = 0;
   int         vectors = 0;
   int         fails = 0;
   int         cyc;

   function automatic int rbase(input int n);
      return DEPTH - n * 512;
   endfunction

   function automatic logic [7:0] exp_byte(input logic [DW-1:0] a);
      return mprot ? 8'h00 : model[a];
   endfunction

   function automatic int dur(input logic [1:0] op);
      case (op)
         2'b00:   return TPROG;
         2'b01:   return TPROT;
         2'b10:   return TPAGE;
         default: return TCHIP;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic unlock();
      wr(SEL_DATA, 8'h55); wr(SEL_DATA, 8'hAA); wr(SEL_DATA, 8'h55);
   endtask

   task automatic run(input logic [1:0] op, output int n);
      wr(SEL_CTRL, {1'b1, 5'b0, op});
      n = 0;
      while (cpu_hold) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic model_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
      int base;
      base = rbase(npages);
      case (op)
         2'b00: if (int'(a) < base) model[a[DW-1:0]] = model[a[DW-1:0]] & d;
         2'b01: mprot = 1'b1;
         2'b10: if (int'(a) < base)
                   for (int i = 0; i < 512; i++) model[{a[DW-1:9], 9'(i)}] = 8'hFF;
         default: begin
            for (int i = 0; i < base; i++) model[i] = 8'hFF;
            mprot = 1'b0;
         end
      endcase
   endtask

   task automatic do_op(input string tag, input logic [1:0] op, input logic [15:0] a,
                        input logic [7:0] d);
      wr(SEL_AHI, a[15:8]);
      wr(SEL_ALO, a[7:0]);
      unlock();
      wr(SEL_DATA, d);
      run(op, cyc);
      check({tag, " run length"}, cyc, dur(op));
      model_op(op, a, d);
   endtask

   task automatic rd_chk(input string tag, input logic [DW-1:0] a);
      @(negedge clk);
      rd_addr = a;
      #1;
      check(tag, {24'd0, rd_data}, {24'd0, exp_byte(a)});
   endtask

   task automatic do_reset(input int n);
      rst_n = 1'b0;
      boot_pages = 4'(n);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      npages = (n > 8) ? 8 : n;
   endtask

   function automatic logic [15:0] exp_boot();
      return (model[0] == 8'hFF && npages != 0) ? 16'(rbase(npages)) : 16'h0000;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [15:0] ra;
      logic [7:0]  rd;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

      // R1 / R11: reset state, blank array, no boot region
      do_reset(0);
      check("R1 hold after reset", cpu_hold, 0);
      check("R11 boot blank n=0", boot_addr, 16'h0000);
      rd_chk("R6 erased reads FF", 12'h123);

      // R4: enable defaults off, so even an armed start is refused
      wr(SEL_AHI, 8'h01); wr(SEL_ALO, 8'h23);
      unlock(); wr(SEL_DATA, 8'h00);
      run(2'b00, cyc);
      check("R4 start refused with enable 0", cyc, 0);
      rd_chk("R4 array untouched", 12'h123);
      wr(SEL_CFG, 8'h01);
      // R3: the refused start left the key armed
      run(2'b00, cyc);
      check("R3 key kept after refused start", cyc, TPROG);
      model_op(2'b00, 16'h0123, 8'h00);
      rd_chk("R6 program to 00", 12'h123);
      // R3: the key is spent after one start
      run(2'b00, cyc);
      check("R3 second start without key", cyc, 0);

      // R2: start without any key
      wr(SEL_ALO, 8'h24); wr(SEL_DATA, 8'h00);
      run(2'b00, cyc);
      check("R2 start without key", cyc, 0);
      rd_chk("R2 no program without key", 12'h124);
      // R2: broken key
      wr(SEL_DATA, 8'h55); wr(SEL_DATA, 8'hAA); wr(SEL_DATA, 8'h12);
      run(2'b00, cyc);
      check("R2 broken key", cyc, 0);
      // R2: repeated 55h restarts at step one
      wr(SEL_DATA, 8'h55); wr(SEL_DATA, 8'h55); wr(SEL_DATA, 8'hAA); wr(SEL_DATA, 8'h55);
      wr(SEL_ALO, 8'h24); wr(SEL_DATA, 8'h3C);
      run(2'b00, cyc);
      check("R2 55h restart arms key", cyc, TPROG);
      model_op(2'b00, 16'h0124, 8'h3C);
      rd_chk("R2 program after restart", 12'h124);
      // R2: other register writes inside the key sequence
      wr(SEL_DATA, 8'h55); wr(SEL_ALO, 8'h25); wr(SEL_DATA, 8'hAA);
      wr(SEL_AHI, 8'h01); wr(SEL_DATA, 8'h55); wr(SEL_DATA, 8'h81);
      run(2'b00, cyc);
      check("R2 key survives other writes", cyc, TPROG);
      model_op(2'b00, 16'h0125, 8'h81);
      rd_chk("R2 program 0125", 12'h125);

      // R6: AND merge
      do_op("R6 program A5", 2'b00, 16'h0200, 8'hA5);
      do_op("R6 program 0F", 2'b00, 16'h0200, 8'h0F);
      rd_chk("R6 AND merge gives 05", 12'h200);

      // R5: writes while held are ignored
      wr(SEL_AHI, 8'h02); wr(SEL_ALO, 8'h10); unlock(); wr(SEL_DATA, 8'hF0);
      wr(SEL_CTRL, 8'h80);
      wr(SEL_ALO, 8'h77);
      wr(SEL_CFG, 8'h00);
      while (cpu_hold) @(negedge clk);
      model_op(2'b00, 16'h0210, 8'hF0);
      unlock(); wr(SEL_DATA, 8'h00);
      run(2'b00, cyc);
      check("R5 enable not cleared while held", cyc, TPROG);
      model_op(2'b00, 16'h0210, 8'h00);
      rd_chk("R5 address kept while held", 12'h210);
      rd_chk("R5 address write dropped", 12'h277);

      // R6 / R8: random programs, some past the array
      for (int k = 0; k < 60; k++) begin
         ra = 16'($urandom());
         if ($urandom() % 4 != 0) ra[15:DW] = '0;
         rd = 8'($urandom());
         do_op("R6 random program", 2'b00, ra, rd);
         rd_chk("R8 random program readback", ra[DW-1:0]);
      end

      // fill the future boot region while it is still open
      do_op("R8 fill C00", 2'b00, 16'h0C00, 8'h11);
      do_op("R8 fill FFF", 2'b00, 16'h0FFF, 8'h22);
      do_op("R8 fill E05", 2'b00, 16'h0E05, 8'h33);

      // R1 / R11: contents persist, boot region of two pages
      do_reset(2);
      rd_chk("R1 contents kept over reset", 12'h200);
      rd_chk("R1 boot area kept", 12'hC00);
      check("R11 boot vector n=2", boot_addr, exp_boot());
      wr(SEL_CFG, 8'h01);

      // R8: boot region and out-of-range guard
      do_op("R8 program in boot region", 2'b00, 16'h0C00, 8'h00);
      rd_chk("R8 boot byte unchanged", 12'hC00);
      do_op("R8 page erase in boot region", 2'b10, 16'h0E05, 8'h00);
      rd_chk("R8 boot page unchanged", 12'hE05);
      do_op("R8 program past array", 2'b00, 16'h1200, 8'h00);
      rd_chk("R8 alias untouched", 12'h200);

      // R7: odd page then even page
      do_op("R7 prep 5FF", 2'b00, 16'h05FF, 8'h00);
      do_op("R7 prep 600", 2'b00, 16'h0600, 8'h00);
      do_op("R7 prep 7FF", 2'b00, 16'h07FF, 8'h00);
      do_op("R7 prep 800", 2'b00, 16'h0800, 8'h00);
      do_op("R7 erase odd page", 2'b10, 16'h07A3, 8'h00);
      rd_chk("R7 odd page low edge", 12'h600);
      rd_chk("R7 odd page high edge", 12'h7FF);
      rd_chk("R7 page below kept", 12'h5FF);
      rd_chk("R7 page above kept", 12'h800);
      do_op("R7 erase even page", 2'b10, 16'h04AB, 8'h00);
      rd_chk("R7 even page high edge", 12'h5FF);
      rd_chk("R7 even page neighbour", 12'h3FF);

      // R10: protection, also across reset
      do_op("R10 protect", 2'b01, 16'h0000, 8'h00);
      rd_chk("R10 protected 200", 12'h200);
      rd_chk("R10 protected C00", 12'hC00);
      do_reset(2);
      rd_chk("R1 protection kept over reset", 12'h123);
      wr(SEL_CFG, 8'h01);

      // R9: chip erase spares boot region, clears protection
      do_op("R9 chip erase", 2'b11, 16'h0000, 8'h00);
      check("R9 protection cleared", {31'd0, mprot}, 0);
      rd_chk("R9 erased 200", 12'h200);
      rd_chk("R9 erased BFF", 12'hBFF);
      rd_chk("R9 boot C00 kept", 12'hC00);
      rd_chk("R9 boot E05 kept", 12'hE05);
      rd_chk("R9 boot FFF kept", 12'hFFF);

      // R11: non-blank byte 0, then blank again, then clamped size
      do_op("R11 program byte 0", 2'b00, 16'h0000, 8'h00);
      do_reset(2);
      check("R11 boot non-blank", boot_addr, 16'h0000);
      wr(SEL_CFG, 8'h01);
      do_op("R11 chip erase", 2'b11, 16'h0000, 8'h00);
      do_reset(3);
      check("R11 boot blank n=3", boot_addr, 16'h0A00);
      do_reset(12);
      check("R11 boot clamped n", boot_addr, exp_boot());

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule